// File: doc/BRIEF.md
# Timer Input Capture Unit

This block keeps a free-running, wrapping timebase counter that advances once every P system clocks. It timestamps events on one capture channel. The event comes from one of two sources, selected by a configuration bit. One source is the level seen on an external pad. The other is the output of an on-chip comparator. The pad level is sampled whatever the pad's direction, so a level that the chip drives out itself can also raise an event. This lets software measure the delay from its own output change to the system's response.

The chosen source passes through a two-stage synchronizer. An optional glitch filter follows, which accepts a new level only after four consecutive samples agree. A trigger stage then qualifies rising edges, falling edges, both edges, or a high level. On every qualified event the counter value of that cycle is stored in the capture register and the capture flag is set. A later event overwrites the stored value. The interrupt request follows the flag when enabled. The flag is cleared in one of two ways, chosen by a mode bit: it clears by itself when the interrupt is acknowledged, or it clears only on an explicit clear strobe from software. A small read port returns the counter, the capture register or the status flags. A second flag records each counter wrap.

Top module: `tcap_unit`

## Requirements
- R1: The counter advances by one on every P-th clock, where P = `cfg_presc` + 1, and it wraps from all-ones to zero. `rd_addr` = 0 returns the counter value.
- R2: A source change that the first synchronizer stage samples at clock edge k produces an event in the cycle after edge k+1 when the filter is off. The capture register then holds the counter value of that cycle. `rd_addr` = 1 returns the capture register.
- R3: `cfg_trig` selects the qualifier: 0 = rising edge, 1 = falling edge, 2 = either edge, 3 = high level. In level mode, a capture happens on every cycle while the qualified level is high. Edges that the mode does not select cause no capture.
- R4: `cfg_src` = 0 selects `pin_in` and `cfg_src` = 1 selects `cmp_in`. Activity on the source that is not selected has no effect.
- R5: With `cfg_filt_en` = 1, the qualified level changes only after four consecutive equal synchronized samples. This delays events by exactly four cycles compared with the unfiltered path. Pulses shorter than four cycles are rejected.
- R6: An event that arrives while the capture flag is already set overwrites the capture register with the new timestamp, and the flag stays set.
- R7: `irq` is high exactly while the capture flag is set and `cfg_irq_en` = 1.
- R8: With `cfg_auto_clr` = 1, `irq_ack` clears the capture flag and `clr_cap` is ignored. With `cfg_auto_clr` = 0, `clr_cap` clears the flag and `irq_ack` is ignored. An event in the same cycle as a clear leaves the flag set.
- R9: The overflow flag sets when the counter wraps from all-ones to zero, and `clr_ovf` clears it. `rd_addr` = 2 returns the status word, with bit 0 = capture flag, bit 1 = overflow flag and all other bits 0.
- R10: After reset the counter, the capture register, both flags and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_presc | input | PRE_W | Prescaler value minus one |
| cfg_trig | input | 2 | Trigger qualifier select |
| cfg_src | input | 1 | Event source select (0 pad, 1 comparator) |
| cfg_filt_en | input | 1 | Glitch filter enable |
| cfg_irq_en | input | 1 | Capture interrupt enable |
| cfg_auto_clr | input | 1 | Flag clear policy (1 clear on acknowledge) |
| pin_in | input | 1 | Pad level, asynchronous |
| cmp_in | input | 1 | Comparator output, asynchronous |
| irq_ack | input | 1 | Interrupt accepted strobe |
| clr_cap | input | 1 | Software capture flag clear strobe |
| clr_ovf | input | 1 | Overflow flag clear strobe |
| rd_addr | input | 2 | Read select: 0 counter, 1 capture, 2 status |
| rd_data | output | CNT_W | Read data |
| irq | output | 1 | Capture interrupt request |
| cap_flag | output | 1 | Capture flag |
| ovf_flag | output | 1 | Counter wrap flag |

## Verification
The bench sweeps every prescaler value from 1 to 4 against every edge mode, both filter settings and both sources. It computes each timestamp from the number of clock edges since reset. An error of one cycle in the synchronizer or filter latency therefore shows up as a wrong timestamp at the larger prescalers, and a divider that is off by one drifts away from the expected count. The bench toggles the source that is not selected, to catch a swapped or ORed source mux. It sends a three-cycle glitch through the filter, to catch a filter that votes on three samples instead of four. It fires two events before a clear and expects the second timestamp, to catch a register that keeps the first value. It also sends each clear strobe while the policy that ignores it is active, to catch a flag that clears on the wrong strobe. The wrap check samples the cycles just before and just after the all-ones value, to catch an overflow flag that sets one step early or late.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        RD_COUNT   = 2'd0,
        RD_CAPTURE = 2'd1,
        RD_STATUS  = 2'd2,
        RD_NONE    = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    localparam int SYNC_STAGES = 2;

    function automatic logic trig_hit(trig_mode_e mode, logic lvl, edge_t e);
        case (mode)
            TRIG_RISE:  return e.rise;
            TRIG_FALL:  return e.fall;
            TRIG_BOTH:  return e.rise | e.fall;
            default:    return lvl;
        endcase
    endfunction

endpackage

// File: rtl/tcap_timebase.sv
module tcap_timebase #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] presc_m1,
    output logic             tick,
    output logic             wrap,
    output logic [CNT_W-1:0] count
);

    logic [PRE_W-1:0] div_q;

    // >= keeps the divider from running the full range if the limit drops
    assign tick = (div_q >= presc_m1);
    assign wrap = tick && (count == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            count <= '0;
        end else if (tick) begin
            div_q <= '0;
            count <= count + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/tcap_event_detect.sv
module tcap_event_detect
    import tcap_pkg::*;
#(
    parameter int FILT_N = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       src_in,
    input  logic       filt_en,
    input  trig_mode_e trig,
    output logic       evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic                   lvl;
    logic                   prev_q;
    edge_t                  edges;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], src_in};
    end
    assign synced = sync_q[SYNC_STAGES-1];

    generate
        if (FILT_N > 1) begin : g_filt
            logic [FILT_N-2:0] hist_q;
            logic [FILT_N-1:0] window;
            logic              flt_q;

            assign window = {hist_q, synced};

            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q <= '0;
                    flt_q  <= 1'b0;
                end else begin
                    hist_q <= window[FILT_N-2:0];
                    if (&window)       flt_q <= 1'b1;
                    else if (~|window) flt_q <= 1'b0;
                end
            end
            assign lvl = filt_en ? flt_q : synced;
        end else begin : g_nofilt
            assign lvl = synced | (filt_en & 1'b0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign edges.rise = lvl & ~prev_q;
    assign edges.fall = ~lvl & prev_q;
    assign evt        = trig_hit(trig, lvl, edges);

endmodule

// File: rtl/tcap_capture.sv
module tcap_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic [CNT_W-1:0] count,
    input  logic             wrap,
    input  logic             auto_clr,
    input  logic             irq_ack,
    input  logic             clr_cap,
    input  logic             clr_ovf,
    output logic [CNT_W-1:0] cap_q,
    output logic             cap_flag,
    output logic             ovf_flag
);

    logic clr_req;

    assign clr_req = auto_clr ? irq_ack : clr_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q    <= '0;
            cap_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (evt) cap_q <= count;
            cap_flag <= evt  | (cap_flag & ~clr_req);
            ovf_flag <= wrap | (ovf_flag & ~clr_ovf);
        end
    end

endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
    import tcap_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 8,
    parameter int FILT_N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] cfg_presc,
    input  logic [1:0]       cfg_trig,
    input  logic             cfg_src,
    input  logic             cfg_filt_en,
    input  logic             cfg_irq_en,
    input  logic             cfg_auto_clr,
    input  logic             pin_in,
    input  logic             cmp_in,
    input  logic             irq_ack,
    input  logic             clr_cap,
    input  logic             clr_ovf,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq,
    output logic             cap_flag,
    output logic             ovf_flag
);

    logic             src_w;
    logic             evt_w;
    logic             tick_w;
    logic             wrap_w;
    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] cap_w;

    assign src_w = cfg_src ? cmp_in : pin_in;

    tcap_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) tb_i (
        .clk      (clk),
        .rst      (rst),
        .presc_m1 (cfg_presc),
        .tick     (tick_w),
        .wrap     (wrap_w),
        .count    (count_w)
    );

    tcap_event_detect #(.FILT_N(FILT_N)) ev_i (
        .clk     (clk),
        .rst     (rst),
        .src_in  (src_w),
        .filt_en (cfg_filt_en),
        .trig    (trig_mode_e'(cfg_trig)),
        .evt     (evt_w)
    );

    tcap_capture #(.CNT_W(CNT_W)) cap_i (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_w),
        .count    (count_w),
        .wrap     (wrap_w),
        .auto_clr (cfg_auto_clr),
        .irq_ack  (irq_ack),
        .clr_cap  (clr_cap),
        .clr_ovf  (clr_ovf),
        .cap_q    (cap_w),
        .cap_flag (cap_flag),
        .ovf_flag (ovf_flag)
    );

    assign irq = cap_flag & cfg_irq_en;

    always_comb begin
        case (rd_sel_e'(rd_addr))
            RD_COUNT:   rd_data = count_w;
            RD_CAPTURE: rd_data = cap_w;
            RD_STATUS:  rd_data = CNT_W'({ovf_flag, cap_flag});
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tcap_unit_chk.sv
module tcap_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             evt,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cap_q,
    input logic             cap_flag,
    input logic             ovf_flag,
    input logic             irq,
    input logic             cfg_auto_clr,
    input logic             irq_ack,
    input logic             clr_cap,
    input logic             clr_ovf
);

    assert_count_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> count == CNT_W'($past(count) + 1'b1));

    assert_capture_value_R2: assert property (@(posedge clk) disable iff (rst)
        evt |=> (cap_flag && cap_q == $past(count)));

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> cap_flag);

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (cap_flag && !(cfg_auto_clr ? irq_ack : clr_cap)) |=> cap_flag);

    assert_flag_sw_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_auto_clr && clr_cap && !evt) |=> !cap_flag);

    assert_ovf_on_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (tick && count == {CNT_W{1'b1}}) |=> ovf_flag);

    assert_ovf_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!ovf_flag && !(tick && count == {CNT_W{1'b1}})) |=> !ovf_flag);

    assert_ovf_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && clr_ovf && !(tick && count == {CNT_W{1'b1}})) |=> !ovf_flag);

endmodule

bind tcap_unit tcap_unit_chk #(.CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .evt          (evt_w),
    .tick         (tick_w),
    .count        (count_w),
    .cap_q        (cap_w),
    .cap_flag     (cap_flag),
    .ovf_flag     (ovf_flag),
    .irq          (irq),
    .cfg_auto_clr (cfg_auto_clr),
    .irq_ack      (irq_ack),
    .clr_cap      (clr_cap),
    .clr_ovf      (clr_ovf)
);

// File: tb/tcap_unit_tb_top.sv
module tcap_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW  = 4;
    localparam int PW  = 3;
    localparam int MOD = 1 << CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] cfg_presc = '0;
    logic [1:0]    cfg_trig = 2'd0;
    logic          cfg_src = 1'b0;
    logic          cfg_filt_en = 1'b0;
    logic          cfg_irq_en = 1'b0;
    logic          cfg_auto_clr = 1'b0;
    logic          pin_in = 1'b0;
    logic          cmp_in = 1'b0;
    logic          irq_ack = 1'b0;
    logic          clr_cap = 1'b0;
    logic          clr_ovf = 1'b0;
    logic [1:0]    rd_addr = 2'd1;
    logic [CW-1:0] rd_data;
    logic          irq;
    logic          cap_flag;
    logic          ovf_flag;

    int n_chk  = 0;
    int n_fail = 0;
    int ecount = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) ecount <= rst ? 0 : ecount + 1;

    tcap_unit #(.CNT_W(CW), .PRE_W(PW), .FILT_N(4)) dut_i (
        .clk(clk), .rst(rst), .cfg_presc(cfg_presc), .cfg_trig(cfg_trig),
        .cfg_src(cfg_src), .cfg_filt_en(cfg_filt_en), .cfg_irq_en(cfg_irq_en),
        .cfg_auto_clr(cfg_auto_clr), .pin_in(pin_in), .cmp_in(cmp_in),
        .irq_ack(irq_ack), .clr_cap(clr_cap), .clr_ovf(clr_ovf),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
        .cap_flag(cap_flag), .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic read_reg(input int a, output int v);
        rd_addr = 2'(a);
        #1 v = int'(rd_data);
    endtask

    task automatic setup(input int p, input int mode, input bit filt, input bit src,
                         input bit autoc, input bit ien);
        @(negedge clk);
        rst = 1'b1;
        cfg_presc = PW'(p - 1);
        cfg_trig = 2'(mode);
        cfg_filt_en = filt;
        cfg_src = src;
        cfg_auto_clr = autoc;
        cfg_irq_en = ien;
        pin_in = 1'b0; cmp_in = 1'b0;
        irq_ack = 1'b0; clr_cap = 1'b0; clr_ovf = 1'b0;
        cyc(2);
        rst = 1'b0;
    endtask

    task automatic drive_sel(input bit src, input bit v);
        if (src) cmp_in = v; else pin_in = v;
    endtask

    task automatic drive_other(input bit src, input bit v);
        if (src) pin_in = v; else cmp_in = v;
    endtask

    task automatic pulse_clr_cap();
        clr_cap = 1'b1; cyc(1); clr_cap = 1'b0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
    endtask

    function automatic int stamp(input int n, input int p, input bit filt);
        return ((n + 2 + (filt ? 4 : 0)) / p) % MOD;
    endfunction

    initial begin : main
        int v, n1, n2, e1, e2;

        // R10 reset state
        setup(1, 0, 0, 0, 0, 1);
        read_reg(0, v); chk(v == 0, "R10 counter", v, 0);
        read_reg(1, v); chk(v == 0, "R10 capture", v, 0);
        read_reg(2, v); chk(v == 0, "R10 status", v, 0);
        chk(irq == 1'b0, "R10 irq", int'(irq), 0);

        // R1 counter rate for several prescalers
        for (int p = 1; p <= 5; p++) begin
            setup(p, 0, 0, 0, 0, 0);
            for (int k = 0; k < 4; k++) begin
                cyc(7 + k);
                read_reg(0, v);
                chk(v == (ecount / p) % MOD, "R1 count", v, (ecount / p) % MOD);
            end
        end

        // Sweep: prescaler x edge mode x filter x source (R2 R3 R4 R5 R8)
        for (int p = 1; p <= 4; p++)
        for (int mode = 0; mode <= 2; mode++)
        for (int f = 0; f <= 1; f++)
        for (int s = 0; s <= 1; s++) begin
            setup(p, mode, f[0], s[0], 0, 1);
            cyc(3 + p + mode);
            drive_other(s[0], 1'b1); cyc(10);
            chk(cap_flag == 1'b0, "R4 unselected rise", int'(cap_flag), 0);
            drive_other(s[0], 1'b0); cyc(10);
            chk(cap_flag == 1'b0, "R4 unselected fall", int'(cap_flag), 0);

            n1 = ecount; drive_sel(s[0], 1'b1); cyc(12);
            e1 = stamp(n1, p, f[0]);
            if (mode != 1) begin
                chk(cap_flag == 1'b1, "R3 rise qualifies", int'(cap_flag), 1);
                read_reg(1, v);
                chk(v == e1, f ? "R5 filtered stamp" : "R2 stamp", v, e1);
            end else begin
                chk(cap_flag == 1'b0, "R3 rise ignored", int'(cap_flag), 0);
            end
            pulse_clr_cap();
            chk(cap_flag == 1'b0, "R8 sw clear", int'(cap_flag), 0);

            cyc(1 + p);
            n2 = ecount; drive_sel(s[0], 1'b0); cyc(12);
            e2 = stamp(n2, p, f[0]);
            if (mode != 0) begin
                chk(cap_flag == 1'b1, "R3 fall qualifies", int'(cap_flag), 1);
                read_reg(1, v);
                chk(v == e2, f ? "R5 filtered stamp" : "R2 stamp", v, e2);
            end else begin
                chk(cap_flag == 1'b0, "R3 fall ignored", int'(cap_flag), 0);
            end
        end

        // R5 glitch rejection, then a long pulse is accepted
        setup(1, 0, 1, 0, 0, 0);
        cyc(5);
        pin_in = 1'b1; cyc(3); pin_in = 1'b0; cyc(12);
        chk(cap_flag == 1'b0, "R5 3-cycle glitch rejected", int'(cap_flag), 0);
        n1 = ecount; pin_in = 1'b1; cyc(4); pin_in = 1'b0; cyc(12);
        chk(cap_flag == 1'b1, "R5 4-cycle pulse accepted", int'(cap_flag), 1);
        read_reg(1, v);
        chk(v == stamp(n1, 1, 1), "R5 pulse stamp", v, stamp(n1, 1, 1));

        // R6 overwrite before clear
        setup(2, 0, 0, 0, 0, 1);
        cyc(3);
        n1 = ecount; pin_in = 1'b1; cyc(4); pin_in = 1'b0; cyc(4);
        n2 = ecount; pin_in = 1'b1; cyc(6);
        read_reg(1, v);
        chk(v == stamp(n2, 2, 0), "R6 second stamp kept", v, stamp(n2, 2, 0));
        chk(cap_flag == 1'b1, "R6 flag still set", int'(cap_flag), 1);
        chk(irq == 1'b1, "R7 irq with enable", int'(irq), 1);

        // R8 software mode ignores acknowledge
        pulse_ack(); cyc(1);
        chk(cap_flag == 1'b1, "R8 ack ignored in sw mode", int'(cap_flag), 1);
        // R7 enable low masks irq
        cfg_irq_en = 1'b0; #1;
        chk(irq == 1'b0, "R7 irq masked", int'(irq), 0);

        // R8 auto-clear mode
        setup(1, 2, 0, 1, 1, 1);
        cyc(3);
        cmp_in = 1'b1; cyc(6);
        chk(irq == 1'b1, "R7 irq asserted", int'(irq), 1);
        pulse_clr_cap(); cyc(1);
        chk(cap_flag == 1'b1, "R8 sw clear ignored in auto mode", int'(cap_flag), 1);
        pulse_ack();
        chk(cap_flag == 1'b0, "R8 ack clears", int'(cap_flag), 0);
        chk(irq == 1'b0, "R8 irq drops", int'(irq), 0);

        // R3 level mode: capture each cycle while high
        setup(1, 3, 0, 0, 0, 0);
        cyc(3);
        pin_in = 1'b1; cyc(8);
        read_reg(1, v);
        chk(v == (ecount - 1) % MOD, "R3 level tracks", v, (ecount - 1) % MOD);
        cyc(3);
        read_reg(1, v);
        chk(v == (ecount - 1) % MOD, "R3 level tracks later", v, (ecount - 1) % MOD);
        pin_in = 1'b0; cyc(6);
        pulse_clr_cap(); cyc(3);
        chk(cap_flag == 1'b0, "R3 level low no event", int'(cap_flag), 0);

        // R9 overflow around the wrap
        setup(1, 0, 0, 0, 0, 0);
        while (ecount != MOD - 1) cyc(1);
        chk(ovf_flag == 1'b0, "R9 no overflow before wrap", int'(ovf_flag), 0);
        read_reg(0, v); chk(v == MOD - 1, "R1 all-ones", v, MOD - 1);
        cyc(1);
        chk(ovf_flag == 1'b1, "R9 overflow at wrap", int'(ovf_flag), 1);
        read_reg(0, v); chk(v == 0, "R1 wraps to zero", v, 0);
        read_reg(2, v); chk(v == 2, "R9 status word", v, 2);
        clr_ovf = 1'b1; cyc(1); clr_ovf = 1'b0;
        chk(ovf_flag == 1'b0, "R9 overflow cleared", int'(ovf_flag), 0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule